// File: doc/BRIEF.md
# Scrambled Reed-Solomon Line Frame Encoder

This block prepares one 64-bit user word per frame period for an optical serial line. Each accepted word is first randomized by a parallel multiplicative scrambler (taps at 39 and 58 bit positions back), which adds no bits. The scrambled payload then gets 16 Reed-Solomon check bits. The check bits come from two interleaved shortened codes over GF(16), each able to correct one 4-bit symbol. Finally a fixed DC-balanced 8-bit sync pattern is placed in front, giving an 88-bit frame.

The frame leaves as a parallel word with a valid strobe, ready for an external serializer. The pipeline has a fixed two-cycle latency and takes one frame per cycle of `in_valid`. The scrambler history runs on across frames, so a receiver can descramble without any shared seed.

Top module: `line_frame_encoder`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_frame` and the scrambler history to zero. Inputs presented while reset is high are ignored, so the first frame after reset is scrambled against an all-zero history.
- R2: `out_valid` is high in exactly those cycles that come two rising edges after a rising edge at which `in_valid` was sampled high.
- R3: On every valid frame, `out_frame[87:80]` equals 8'h5A, which has four ones and four zeros.
- R4: `out_frame[63:0]` is the scrambled payload. Taking `in_word` bit 0 first and running on through the stream of accepted words, output bit y[n] = d[n] ^ y[n-39] ^ y[n-58].
- R5: The scrambler history advances only on accepted words. Any number of idle cycles between two words leaves their scrambled payloads unchanged.
- R6: Check bits use GF(16) with x^4+x+1. Codeword c (c = 0, 1) takes payload nibbles 2j+c (j = 0..7) as the coefficients of x^(9-j), followed by `out_frame[64+8c+7 : 64+8c+4]` at x^1 and `out_frame[64+8c+3 : 64+8c]` at x^0. Both syndromes, at alpha = 2 and at alpha^2 = 4, are zero. An all-zero payload gives all-zero check bits.
- R7: When no frame completes in a cycle, `out_frame` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_word` at this edge |
| in_word | input | 64 | User payload word |
| out_valid | output | 1 | `out_frame` holds a new frame |
| out_frame | output | 88 | {header, check bits, scrambled payload} |

## Verification
The scrambler's carried history and the parity of the current frame meet in the same cycle when words arrive back to back. Frame N+1 is scrambled while frame N's check bits are still being formed, so any stall or misordering between the two stages would corrupt one of them. The bench drives runs with no gap, then runs with long gaps. It judges every frame three ways: against a bit-serial scrambler model, by the header, and by recomputing both syndromes from the frame alone. A reset asserted while `in_valid` is held high is also checked, because there the reset and an accept fall on the same edge.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

    localparam int PAY_W   = 64;
    localparam int PAR_W   = 16;
    localparam int HDR_W   = 8;
    localparam int FRAME_W = HDR_W + PAR_W + PAY_W;
    localparam int SYM_W   = 4;
    localparam int N_CW    = 2;
    localparam int K_SYM   = PAY_W / (SYM_W * N_CW);
    localparam int TAP_NEAR = 39;
    localparam int TAP_FAR  = 58;

    localparam logic [HDR_W-1:0] SYNC_HDR = 8'h5A;
    localparam logic [SYM_W-1:0] GEN_C1   = 4'h6;  // alpha + alpha^2
    localparam logic [SYM_W-1:0] GEN_C0   = 4'h8;  // alpha^3

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic [PAR_W-1:0] par;
        logic [PAY_W-1:0] pay;
    } frame_t;

    // GF(16) multiply, field polynomial x^4 + x + 1
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc, sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? 4'b0011 : 4'b0000);
        end
        return acc;
    endfunction

    // Payload symbol j of interleaved codeword c
    function automatic logic [SYM_W-1:0] pay_sym(input logic [PAY_W-1:0] d,
                                                 input int c, input int j);
        return d[(2*j+c)*SYM_W +: SYM_W];
    endfunction

    // Horner evaluation of codeword c at point x
    function automatic logic [SYM_W-1:0] cw_eval(input logic [PAY_W-1:0] d,
                                                 input logic [PAR_W-1:0] p,
                                                 input int c,
                                                 input logic [SYM_W-1:0] x);
        logic [SYM_W-1:0] s;
        s = '0;
        for (int j = 0; j < K_SYM; j++) s = gf_mul(s, x) ^ pay_sym(d, c, j);
        s = gf_mul(s, x) ^ p[8*c+4 +: SYM_W];
        s = gf_mul(s, x) ^ p[8*c   +: SYM_W];
        return s;
    endfunction

endpackage

// File: rtl/lfe_scrambler.sv
module lfe_scrambler #(
    parameter int W    = 64,
    parameter int TAPA = 39,
    parameter int TAPB = 58
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int HIST = TAPB;
    localparam int ZW   = HIST + W;

    // hist[HIST-1] is the most recent scrambled bit
    logic [HIST-1:0] hist;
    logic [ZW-1:0]   z;

    always_comb begin
        z = '0;
        z[HIST-1:0] = hist;
        for (int t = HIST; t < ZW; t++)
            z[t] = din[t-HIST] ^ z[t-TAPA] ^ z[t-TAPB];
    end

    assign dout = z[ZW-1:HIST];

    always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= z[ZW-1:ZW-HIST];
    end

    // R5: idle cycles leave the history untouched
    a_r5_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(hist));

    // R1: reset empties the history
    a_r1_hist_clear: assert property (@(posedge clk)
        rst |=> (hist == '0));

endmodule

// File: rtl/lfe_rs_parity.sv
module lfe_rs_parity
    import lfe_pkg::*;
(
    input  logic [PAY_W-1:0] data,
    output logic [PAR_W-1:0] parity
);
    for (genvar c = 0; c < N_CW; c++) begin : g_cw
        logic [SYM_W-1:0] r1, r0, fb;
        always_comb begin
            r1 = '0;
            r0 = '0;
            fb = '0;
            for (int j = 0; j < K_SYM; j++) begin
                fb = pay_sym(data, c, j) ^ r1;
                r1 = r0 ^ gf_mul(fb, GEN_C1);
                r0 = gf_mul(fb, GEN_C0);
            end
        end
        assign parity[8*c +: 8] = {r1, r0};
    end

    // R6: every codeword has zero syndromes at alpha and alpha^2
    always_comb begin
        a_r6_syndromes: assert (cw_eval(data, parity, 0, 4'h2) == '0 &&
                                cw_eval(data, parity, 0, 4'h4) == '0 &&
                                cw_eval(data, parity, 1, 4'h2) == '0 &&
                                cw_eval(data, parity, 1, 4'h4) == '0);
    end

endmodule

// File: rtl/line_frame_encoder.sv
module line_frame_encoder
    import lfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PAY_W-1:0]   in_word,
    output logic               out_valid,
    output logic [FRAME_W-1:0] out_frame
);
    logic [PAY_W-1:0] scr_word;
    logic [PAY_W-1:0] s1_pay;
    logic             s1_valid;
    logic [PAR_W-1:0] s1_par;
    frame_t           frame_q;
    logic [1:0]       warm;

    lfe_scrambler #(.W(PAY_W), .TAPA(TAP_NEAR), .TAPB(TAP_FAR)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .din  (in_word),
        .dout (scr_word)
    );

    // stage 1: scrambled payload
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_pay   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_pay <= scr_word;
        end
    end

    lfe_rs_parity u_rs (
        .data   (s1_pay),
        .parity (s1_par)
    );

    // stage 2: assembled frame
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            frame_q   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) frame_q <= '{hdr: SYNC_HDR, par: s1_par, pay: s1_pay};
        end
    end

    assign out_frame = frame_q;

    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R2: fixed two-edge latency
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R3: sync header balanced and in front
    a_r3_header: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_frame[FRAME_W-1 -: HDR_W]) == 4 &&
                       out_frame[FRAME_W-1 -: HDR_W] == SYNC_HDR));

    // R7: frame holds while nothing completes
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_frame));

endmodule

// File: tb/tb_line_frame_encoder.sv
module tb_line_frame_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic        out_valid;
    logic [87:0] out_frame;

    int n_tests = 0;
    int n_fail  = 0;

    line_frame_encoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_frame(out_frame)
    );

    always #10 clk = ~clk;

    // stimulus table: {idle gap after word, word}
    localparam logic [71:0] VEC [10] = '{
        {8'd0, 64'h0000_0000_0000_0000},
        {8'd0, 64'hFFFF_FFFF_FFFF_FFFF},
        {8'd3, 64'h0123_4567_89AB_CDEF},
        {8'd0, 64'h8000_0000_0000_0001},
        {8'd0, 64'hDEAD_BEEF_CAFE_F00D},
        {8'd7, 64'hA5A5_5A5A_0F0F_F0F0},
        {8'd1, 64'h0000_0000_0000_0001},
        {8'd0, 64'h7FFF_FFFF_FFFF_FFFE},
        {8'd12, 64'h1357_9BDF_2468_ACE0},
        {8'd2, 64'hFEDC_BA98_7654_3210}
    };

    logic [57:0] hist = '0;        // hist[0] = last scrambled bit
    logic [63:0] exp_q [$];
    logic        hv1 = 1'b0;
    logic        mon_on = 1'b0;
    logic        have_last = 1'b0;
    logic [87:0] last_frame = '0;
    logic [63:0] e;

    task automatic fail(input string req, input logic [87:0] act, input logic [87:0] exp);
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    // bit-serial scrambler model
    task automatic push_expected(input logic [63:0] d);
        logic [63:0] y;
        logic b;
        for (int i = 0; i < 64; i++) begin
            b = d[i] ^ hist[38] ^ hist[57];
            y[i] = b;
            hist = {hist[56:0], b};
        end
        exp_q.push_back(y);
    endtask

    function automatic logic [3:0] gm(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
        for (int k = 7; k >= 4; k--) if (p[k]) p = p ^ (8'b0001_0011 << (k - 4));
        return p[3:0];
    endfunction

    function automatic logic [3:0] synd(input logic [87:0] f, input int c, input logic [3:0] x);
        logic [3:0] s;
        s = '0;
        for (int j = 0; j < 8; j++) s = gm(s, x) ^ f[(2*j+c)*4 +: 4];
        s = gm(s, x) ^ f[64 + 8*c + 4 +: 4];
        s = gm(s, x) ^ f[64 + 8*c +: 4];
        return s;
    endfunction

    // monitor: after every rising edge
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (hv1 || out_valid) begin
                n_tests++;
                if (out_valid !== hv1) fail("R2 latency", 88'(out_valid), 88'(hv1));
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_tests++;
                    fail("R2 unexpected frame", out_frame, '0);
                end else begin
                    e = exp_q.pop_front();
                    n_tests++;
                    if (out_frame[87:80] !== 8'h5A) fail("R3 header", 88'(out_frame[87:80]), 88'h5A);
                    n_tests++;
                    if (out_frame[63:0] !== e) fail("R4/R5 payload", 88'(out_frame[63:0]), 88'(e));
                    for (int c = 0; c < 2; c++) begin
                        n_tests++;
                        if (synd(out_frame, c, 4'h2) !== 4'h0 || synd(out_frame, c, 4'h4) !== 4'h0)
                            fail("R6 syndrome", out_frame, '0);
                    end
                end
                last_frame = out_frame;
                have_last  = 1'b1;
            end else if (have_last) begin
                n_tests++;
                if (out_frame !== last_frame) fail("R7 hold", out_frame, last_frame);
            end
        end
        hv1 = in_valid;
    end

    task automatic drive(input logic [63:0] w, input int gap);
        in_valid = 1'b1;
        in_word  = w;
        push_expected(w);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // reset with in_valid held high, which must be ignored (R1)
    task automatic do_reset();
        @(negedge clk);
        mon_on    = 1'b0;
        rst       = 1'b1;
        in_valid  = 1'b1;
        in_word   = 64'hBADC_0FFE_E0DD_F00D;
        exp_q.delete();
        hist      = '0;
        have_last = 1'b0;
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) fail("R1 reset valid", 88'(out_valid), '0);
        n_tests++;
        if (out_frame !== '0) fail("R1 reset frame", out_frame, '0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
    endtask

    initial begin
        do_reset();
        // table walk: back-to-back runs and idle gaps (R2..R7)
        for (int v = 0; v < 10; v++) drive(VEC[v][63:0], int'(VEC[v][71:64]));
        repeat (4) @(negedge clk);

        // R1/R6: zero word after reset, full frame known exactly
        do_reset();
        drive(64'h0, 0);
        @(negedge clk);
        n_tests++;
        if (out_frame !== {8'h5A, 16'h0, 64'h0}) fail("R1/R6 zero frame", out_frame, {8'h5A, 16'h0, 64'h0});

        // R5: long back-to-back burst, then a long idle gap
        for (int k = 0; k < 20; k++) drive({k[31:0], ~k[31:0]} ^ 64'h9E37_79B9_7F4A_7C15, 0);
        repeat (30) @(negedge clk);
        drive(64'hFFFF_0000_FFFF_0000, 0);
        drive(64'h0000_FFFF_0000_FFFF, 5);
        repeat (4) @(negedge clk);

        // R4: single set bit at the last position after reset
        do_reset();
        drive(64'h8000_0000_0000_0000, 0);
        drive(64'h0, 0);
        repeat (4) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) fail("R2 frames missing", 88'(exp_q.size()), '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule